// File: doc/BRIEF.md
# Dual-Lane Link Bring-Up Controller

This block sequences the logical-layer bring-up of a serial link built from two high-speed lanes and chooses what each lane transmits at every cycle. After reset both lanes sit in electrical idle in a disabled state. Decoded sideband resume events wake the lanes one by one into a lock-training phase. In that phase each awake lane sends a PRBS11 symbol-lock pattern while the transmit equalizers are negotiated.

Negotiation is complete when both receiver-locked flags are high and the receiver-request flag is low. The two lanes then send TS2 ordered sets for a fixed number of cycles and one de-skew ordered set, and join into one bonded link that carries idle packets. If a timeout expires in lock training while only the primary lane has locked, the controller falls back to single-lane operation. A lane-off sideband command sends the controller to sleep from any state. From sleep, a new primary resume starts training again.

States and transitions:
- DISABLED (code 0) goes to LOCK_TRAIN on a primary resume.
- LOCK_TRAIN (1) goes to TS2_SEND when negotiation completes. It goes to ACTIVE_SINGLE on fallback.
- TS2_SEND (2) goes to DESKEW_SEND after `TS2_CYC` cycles.
- DESKEW_SEND (3) goes to ACTIVE_BONDED after one cycle.
- ACTIVE_BONDED (4) and ACTIVE_SINGLE (5) hold.
- SLEEP (6) goes to LOCK_TRAIN on a primary resume.
- A lane-off command in any state goes to SLEEP.

Top module: `lane_bringup_ctrl`

## Requirements
- R1: After reset, `link_state` is 0, both lane patterns are 0 (electrical idle), `lock_bit` is 0 and `bonded` is 0.
- R2: `sb_resume[0]` in DISABLED moves the controller to LOCK_TRAIN (state 1) on the next clock edge. Lane 0 then shows pattern 1 (lock pattern). Lane 1 stays at 0 until it has its own resume.
- R3: `sb_resume[1]`, seen in DISABLED, LOCK_TRAIN or SLEEP, marks lane 1 awake. While the state is LOCK_TRAIN, an awake lane 1 shows pattern 1.
- R4: While a lane shows pattern 1, its `lock_bit` is bit 10 of an 11-bit LFSR. The LFSR starts at all ones in the first cycle of the pattern and then shifts each cycle as s <= {s[9:0], s[10]^s[8]} (x^11 + x^9 + 1). A lane restarts from the seed each time it begins the pattern, and `lock_bit` is 0 for a lane not showing pattern 1.
- R5: LOCK_TRAIN is held until `rx_locked` is 2'b11, `rx_request` is 0 and lane 1 is awake. `rx_request` = 1 blocks the exit.
- R6: When negotiation completes, state 2 follows on the next edge. Both lanes show pattern 2 (TS2) for exactly `TS2_CYC` cycles.
- R7: Exactly one cycle of state 3 follows, with both lanes at pattern 3 (de-skew). Then state 4 is entered, with both lanes at pattern 4 (idle packets) and `bonded` = 1.
- R8: The controller may spend `TIMEOUT_CYC` cycles in LOCK_TRAIN. If at the end of them `rx_locked[0]` = 1 and `rx_request` = 0 but bonding is not possible, it enters state 5. In state 5 lane 0 shows pattern 4, lane 1 shows pattern 0 and `bonded` = 0. Without primary lock it stays in LOCK_TRAIN.
- R9: `sb_lane_off` moves the controller from any state to SLEEP (state 6) on the next edge. In SLEEP both lanes show pattern 0 and `bonded` = 0. A later `sb_resume[0]` re-enters LOCK_TRAIN.
- R10: Resume events in states 2 to 5 have no effect on state, patterns or `bonded`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sb_resume | input | 2 | Decoded resume event per lane (bit 0 primary) |
| sb_lane_off | input | 1 | Decoded lane-off sideband command |
| rx_locked | input | 2 | Receiver-locked flag per lane |
| rx_request | input | 1 | Receiver still requesting equalizer changes |
| lane0_pat | output | 3 | Lane 0 pattern: 0 idle, 1 lock, 2 TS2, 3 de-skew, 4 idle packets |
| lane1_pat | output | 3 | Lane 1 pattern, same encoding |
| lock_bit | output | 2 | Per-lane PRBS11 output bit |
| link_state | output | 3 | State code 0..6 |
| bonded | output | 1 | Dual-lane link established |

## Verification
The state is a register and every output is a Moore decode of it. Each result is therefore due one clock edge after the stimulus cycle. Each table row is driven at a falling edge and checked at the next falling edge.

Counted windows are checked at their first and last cycles, in the exact cycle where they are due:
- TS2 runs `TS2_CYC` cycles from the edge that completes negotiation.
- The fallback falls at observation `TIMEOUT_CYC` after the resume edge.

The PRBS stream is compared bit by bit each cycle against a bench-side LFSR, starting at the first cycle of the pattern.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

    typedef enum logic [2:0] {
        ST_DISABLED = 3'd0,
        ST_LOCK     = 3'd1,
        ST_TS2      = 3'd2,
        ST_DESKEW   = 3'd3,
        ST_BONDED   = 3'd4,
        ST_SINGLE   = 3'd5,
        ST_SLEEP    = 3'd6
    } lbc_state_e;

    typedef enum logic [2:0] {
        PAT_EI     = 3'd0,
        PAT_LOCK   = 3'd1,
        PAT_TS2    = 3'd2,
        PAT_DESKEW = 3'd3,
        PAT_IDLE   = 3'd4
    } lbc_pat_e;

    localparam int unsigned PRBS_W = 11;

endpackage

// File: rtl/lbc_cycle_timer.sv
// Counts cycles while run is high, clears when run is low, saturates at LIMIT-1.
module lbc_cycle_timer #(
    parameter int unsigned LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int unsigned CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R8
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0); // R6

endmodule

// File: rtl/lbc_prbs11.sv
// PRBS11 source, x^11 + x^9 + 1; sits at the all-ones seed while not running.
module lbc_prbs11 (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic bit_o
);
    import lbc_pkg::*;

    logic [PRBS_W-1:0] lfsr;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            lfsr <= '1;
        end else begin
            lfsr <= {lfsr[PRBS_W-2:0], lfsr[10] ^ lfsr[8]};
        end
    end

    assign bit_o = run & lfsr[10];

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0); // R4
    AST_LFSR_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> lfsr == '1); // R4

endmodule

// File: rtl/lane_bringup_ctrl.sv
module lane_bringup_ctrl #(
    parameter int unsigned TS2_CYC     = 16,
    parameter int unsigned TIMEOUT_CYC = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sb_resume,
    input  logic       sb_lane_off,
    input  logic [1:0] rx_locked,
    input  logic       rx_request,
    output logic [2:0] lane0_pat,
    output logic [2:0] lane1_pat,
    output logic [1:0] lock_bit,
    output logic [2:0] link_state,
    output logic       bonded
);
    import lbc_pkg::*;

    localparam int unsigned NLANE = 2;

    lbc_state_e state, nxt;
    logic       lane1_awake;
    logic       ts2_done, lock_timeout;
    logic       neg_done;
    lbc_pat_e   pat [NLANE];
    logic [NLANE-1:0] lock_run;

    // Negotiation is complete only with both lanes locked and no request pending.
    assign neg_done = (rx_locked == 2'b11) && !rx_request && lane1_awake;

    lbc_cycle_timer #(.LIMIT(TS2_CYC)) u_ts2_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_TS2),
        .done  (ts2_done)
    );

    lbc_cycle_timer #(.LIMIT(TIMEOUT_CYC)) u_lock_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_LOCK),
        .done  (lock_timeout)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_DISABLED;
        end else begin
            state <= nxt;
        end
    end

    // Secondary-lane wake flag
    always_ff @(posedge clk) begin
        if (!rst_n || sb_lane_off) begin
            lane1_awake <= 1'b0;
        end else if (sb_resume[1] &&
                     (state == ST_DISABLED || state == ST_LOCK || state == ST_SLEEP)) begin
            lane1_awake <= 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_DISABLED: if (sb_resume[0]) nxt = ST_LOCK;
            ST_LOCK: begin
                if (neg_done) begin
                    nxt = ST_TS2;
                end else if (lock_timeout && rx_locked[0] && !rx_request) begin
                    nxt = ST_SINGLE;
                end
            end
            ST_TS2:      if (ts2_done) nxt = ST_DESKEW;
            ST_DESKEW:   nxt = ST_BONDED;
            ST_BONDED:   nxt = ST_BONDED;
            ST_SINGLE:   nxt = ST_SINGLE;
            ST_SLEEP:    if (sb_resume[0]) nxt = ST_LOCK;
            default:     nxt = ST_DISABLED;
        endcase
        if (sb_lane_off) nxt = ST_SLEEP;
    end

    // Output decode
    always_comb begin
        pat[0] = PAT_EI;
        pat[1] = PAT_EI;
        bonded = 1'b0;
        unique case (state)
            ST_DISABLED, ST_SLEEP: ;
            ST_LOCK: begin
                pat[0] = PAT_LOCK;
                pat[1] = lane1_awake ? PAT_LOCK : PAT_EI;
            end
            ST_TS2: begin
                pat[0] = PAT_TS2;
                pat[1] = PAT_TS2;
            end
            ST_DESKEW: begin
                pat[0] = PAT_DESKEW;
                pat[1] = PAT_DESKEW;
            end
            ST_BONDED: begin
                pat[0] = PAT_IDLE;
                pat[1] = PAT_IDLE;
                bonded = 1'b1;
            end
            ST_SINGLE:   pat[0] = PAT_IDLE;
            default: ;
        endcase
    end

    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_lane
            assign lock_run[g] = (pat[g] == PAT_LOCK);
            lbc_prbs11 u_prbs (
                .clk   (clk),
                .rst_n (rst_n),
                .run   (lock_run[g]),
                .bit_o (lock_bit[g])
            );
        end
    endgenerate

    assign lane0_pat  = pat[0];
    assign lane1_pat  = pat[1];
    assign link_state = state;

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        sb_lane_off |=> link_state == 3'd6); // R9
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK && !(rx_locked == 2'b11 && !rx_request) && !lock_timeout && !sb_lane_off)
        |=> state == ST_LOCK); // R5
    AST_TS2_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TS2 && !sb_lane_off) |=> (state == ST_TS2 || state == ST_DESKEW)); // R6
    AST_DESKEW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DESKEW && !sb_lane_off) |=> bonded); // R7
    AST_BOND_AFTER_DESKEW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bonded) |-> $past(lane0_pat) == 3'd3); // R7
    AST_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK && lock_timeout && rx_locked == 2'b01 && !rx_request && !sb_lane_off)
        |=> state == ST_SINGLE); // R8
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_BONDED || state == ST_SINGLE) && !sb_lane_off) |=> $stable(state)); // R10

endmodule

// File: tb/sim_lane_bringup_ctrl.sv
module sim_lane_bringup_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int TS2_N      = 4;
    localparam int TMO_N      = 20;
    localparam int NVEC       = 13;

    // Vector: [15:14] resume, [13] lane_off, [12:11] rx_locked, [10] rx_request,
    //         [9:7] exp state, [6:4] exp lane0 pat, [3:1] exp lane1 pat, [0] exp bonded
    localparam logic [15:0] VEC [NVEC] = '{
        {2'b01, 1'b0, 2'b00, 1'b0, 3'd1, 3'd1, 3'd0, 1'b0}, // R2 primary resume
        {2'b10, 1'b0, 2'b00, 1'b0, 3'd1, 3'd1, 3'd1, 1'b0}, // R3 secondary resume
        {2'b00, 1'b0, 2'b11, 1'b1, 3'd1, 3'd1, 3'd1, 1'b0}, // R5 request blocks
        {2'b00, 1'b0, 2'b01, 1'b0, 3'd1, 3'd1, 3'd1, 1'b0}, // R5 one lane locked
        {2'b00, 1'b0, 2'b11, 1'b0, 3'd2, 3'd2, 3'd2, 1'b0}, // R6 TS2 cycle 1
        {2'b00, 1'b0, 2'b00, 1'b0, 3'd2, 3'd2, 3'd2, 1'b0}, // R6 TS2 cycle 2
        {2'b00, 1'b0, 2'b00, 1'b0, 3'd2, 3'd2, 3'd2, 1'b0}, // R6 TS2 cycle 3
        {2'b00, 1'b0, 2'b00, 1'b0, 3'd2, 3'd2, 3'd2, 1'b0}, // R6 TS2 cycle 4
        {2'b00, 1'b0, 2'b00, 1'b0, 3'd3, 3'd3, 3'd3, 1'b0}, // R7 de-skew
        {2'b00, 1'b0, 2'b00, 1'b0, 3'd4, 3'd4, 3'd4, 1'b1}, // R7 bonded
        {2'b11, 1'b0, 2'b00, 1'b1, 3'd4, 3'd4, 3'd4, 1'b1}, // R10 resume ignored
        {2'b00, 1'b1, 2'b00, 1'b0, 3'd6, 3'd0, 3'd0, 1'b0}, // R9 lane-off
        {2'b01, 1'b0, 2'b00, 1'b0, 3'd1, 3'd1, 3'd0, 1'b0}  // R9 wake from sleep
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] sb_resume;
    logic       sb_lane_off;
    logic [1:0] rx_locked;
    logic       rx_request;
    logic [2:0] lane0_pat, lane1_pat, link_state;
    logic [1:0] lock_bit;
    logic       bonded;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_bringup_ctrl #(.TS2_CYC(TS2_N), .TIMEOUT_CYC(TMO_N)) u0 (
        .clk(clk), .rst_n(rst_n), .sb_resume(sb_resume), .sb_lane_off(sb_lane_off),
        .rx_locked(rx_locked), .rx_request(rx_request),
        .lane0_pat(lane0_pat), .lane1_pat(lane1_pat), .lock_bit(lock_bit),
        .link_state(link_state), .bonded(bonded)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [1:0] res, input logic off, input logic [1:0] lk, input logic req);
        sb_resume   = res;
        sb_lane_off = off;
        rx_locked   = lk;
        rx_request  = req;
    endtask

    task automatic do_reset();
        drive(2'b00, 1'b0, 2'b00, 1'b0);
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic check_outs(input string tag, input int st, input int p0, input int p1, input int b);
        check({tag, " state"}, int'(link_state), st);
        check({tag, " lane0"}, int'(lane0_pat), p0);
        check({tag, " lane1"}, int'(lane1_pat), p1);
        check({tag, " bonded"}, int'(bonded), b);
    endtask

    initial begin
        logic [10:0] m0, m1;
        do_reset();
        @(negedge clk);
        check_outs("R1 reset", 0, 0, 0, 0);
        check("R1 lock_bit", int'(lock_bit), 0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][15:14], VEC[i][13], VEC[i][12:11], VEC[i][10]);
            step();
            check_outs($sformatf("vector %0d", i), int'(VEC[i][9:7]), int'(VEC[i][6:4]),
                       int'(VEC[i][3:1]), int'(VEC[i][0]));
            if (VEC[i][9:7] == 3'd4)
                check("R4 no prbs in bonded", int'(lock_bit), 0);
        end

        // R4: PRBS stream per lane, lane 1 restarting from the seed
        do_reset();
        drive(2'b01, 1'b0, 2'b00, 1'b0);
        step();
        drive(2'b00, 1'b0, 2'b00, 1'b0);
        m0 = '1;
        m1 = '1;
        for (int k = 0; k < 40; k++) begin
            check("R4 lane0 prbs", int'(lock_bit[0]), int'(m0[10]));
            if (k >= 10) check("R4 lane1 prbs", int'(lock_bit[1]), int'(m1[10]));
            else         check("R4 lane1 quiet", int'(lock_bit[1]), 0);
            if (k == 9) sb_resume = 2'b10;
            else        sb_resume = 2'b00;
            step();
            m0 = {m0[9:0], m0[10] ^ m0[8]};
            if (k >= 10) m1 = {m1[9:0], m1[10] ^ m1[8]};
        end

        // R8: no primary lock -> stay in lock training past the timeout
        do_reset();
        drive(2'b01, 1'b0, 2'b00, 1'b0);
        step();
        drive(2'b00, 1'b0, 2'b00, 1'b0);
        repeat (TMO_N + 5) step();
        check("R8 hold without lock", int'(link_state), 1);

        // R8: fallback lands exactly after TIMEOUT cycles
        do_reset();
        drive(2'b01, 1'b0, 2'b01, 1'b0);
        step();
        sb_resume = 2'b00;
        repeat (TMO_N - 1) step();
        check("R8 still training", int'(link_state), 1);
        step();
        check_outs("R8 single", 5, 4, 0, 0);
        drive(2'b11, 1'b0, 2'b11, 1'b0);
        step();
        check_outs("R10 single holds", 5, 4, 0, 0);

        // R9: lane-off during TS2
        do_reset();
        drive(2'b11, 1'b0, 2'b11, 1'b0);
        step();
        check("R3 both awake", int'(lane1_pat), 1);
        drive(2'b00, 1'b0, 2'b11, 1'b0);
        step();
        check("R6 TS2 entry", int'(link_state), 2);
        drive(2'b00, 1'b1, 2'b00, 1'b0);
        step();
        check_outs("R9 sleep from TS2", 6, 0, 0, 0);

        // R1: reset from bonded
        drive(2'b11, 1'b0, 2'b11, 1'b0);
        step();
        drive(2'b00, 1'b0, 2'b11, 1'b0);
        repeat (TS2_N + 3) step();
        check("R7 bonded before reset", int'(bonded), 1);
        do_reset();
        @(negedge clk);
        check_outs("R1 reset from bonded", 0, 0, 0, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule